// File: doc/BRIEF.md
# Serial Audio Port Clock Master

This block produces the bit clock and the left/right frame clock of one serial audio port. It runs on a single core clock. Each of the two master-clock sources arrives as a one-cycle tick strobe that marks a rising edge of that source. An 8-bit control word is loaded through a one-cycle write strobe. It selects one source tick stream and applies a pre-divider of 1, 1.5, 2 or 3. It also selects a single- or double-speed frame ratio and decides whether the port masters its clocks or follows clocks supplied from outside.

In master mode a sub-clock counter advances on every divided tick. The frame clock and the bit clock are taken from fixed bits of that counter, so every output transition lines up with a selected source edge. In slave mode the external clock pins are handed straight to the port logic. A separate float input turns off the pin drivers while the port stays in master mode. The control word can be read back at any time.

Top module: `audio_clk_master`

## Requirements
- R1: After reset the control word reads 0x00: slave, divide by 1, single speed, first source. Both pin output enables are low.
- R2: The read-back port always shows the last written word with bits 4, 3 and 1 forced to zero. For example, writing 0xFF reads back 0xE5 and writing 0x1A reads back 0x00.
- R3: Control bits 7:6 pick the pre-divider. Code 00 passes every selected tick. Code 01 passes two ticks out of every three, namely the first and second of each group. Code 10 passes the first tick of every two. Code 11 passes the first tick of every three.
- R4: Control bit 0 selects the tick stream: 0 selects the first source and 1 selects the second. Ticks on the stream that is not selected have no effect.
- R5: Control bit 2 sets the speed. When it is 0 (single speed), the frame clock period is 256 divided ticks and is taken from counter bit 7, and the bit clock is taken from counter bit 1. When it is 1 (double speed), the frame clock period is 128 divided ticks and is taken from bit 6, and the bit clock is taken from bit 0. In both modes the frame holds 64 bit-clock periods.
- R6: A register write clears the sub-clock counter and the pre-divider phase. After the write, the frame clock starts low (left channel) and the bit clock starts low. A tick arriving in the same cycle as the write is discarded.
- R7: Control bit 5 set to 1 makes the port master, and the port-side clocks then carry the generated clocks. Set to 0, it makes the port slave, and the port-side clocks then equal the external clock inputs.
- R8: Each pin output enable is high only when the port is master and the float input is 0. In slave mode both enables are low whatever the float input is.
- R9: The generated clocks change only in the cycle after a divided tick or a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Control word write strobe |
| regWrData | input | 8 | Control word to write |
| regRdData | output | 8 | Control word read-back |
| floatClks | input | 1 | Float the clock pins while in master mode |
| mclkTick1 | input | 1 | Edge tick of the first master clock |
| mclkTick2 | input | 1 | Edge tick of the second master clock |
| bclkIn | input | 1 | Bit clock from the pin (slave) |
| lrckIn | input | 1 | Frame clock from the pin (slave) |
| bclkOut | output | 1 | Bit clock driven to the pin |
| lrckOut | output | 1 | Frame clock driven to the pin |
| bclkOe | output | 1 | Bit clock pin output enable |
| lrckOe | output | 1 | Frame clock pin output enable |
| bclkPort | output | 1 | Bit clock delivered to the port logic |
| lrckPort | output | 1 | Frame clock delivered to the port logic |

## Verification
A control write takes effect at the clock edge that captures it. The read-back, the cleared clocks and the output enables are therefore all due at the next falling edge. A tick presented before a rising edge moves the counter at that edge, so its effect on the clocks is also visible at the following falling edge. The pin muxes and the enables are combinational from registers and the float and external-clock inputs, so they settle in the same cycle their inputs change. The bench drives every input on a falling edge and compares on the next falling edge. Its expected clocks come from a running count of selected ticks since the last write, turned into a divided count by arithmetic for each pre-divider code.

// File: rtl/acm_pkg.sv
package acm_pkg;

  typedef enum logic [1:0] {
    DIV_1   = 2'b00,
    DIV_1P5 = 2'b01,
    DIV_2   = 2'b10,
    DIV_3   = 2'b11
  } divSel_e;

  // strobes from control to the clock datapath
  typedef struct packed {
    logic clr;   // clear the sub-clock counter
    logic adv;   // divided tick: advance the counter
    logic dbl;   // double-speed frame ratio
  } cgStrobe_t;

  localparam int unsigned CTRL_W   = 8;
  localparam int unsigned DIV_HI   = 7;
  localparam int unsigned DIV_LO   = 6;
  localparam int unsigned MS_BIT   = 5;
  localparam int unsigned SPD_BIT  = 2;
  localparam int unsigned SRC_BIT  = 0;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 8'hE5;

endpackage

// File: rtl/acm_ctrl.sv
module acm_ctrl
  import acm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CTRL_W-1:0] wrData,
  input  logic              tick1,
  input  logic              tick2,
  output logic [CTRL_W-1:0] ctrlQ,
  output logic              isMaster,
  output cgStrobe_t         strobe
);

  logic [1:0] phase;
  logic [1:0] wrapAt;
  logic       fire;
  logic       srcTick;
  divSel_e    divCode;

  always_comb begin
    srcTick = ctrlQ[SRC_BIT] ? tick2 : tick1;
    divCode = divSel_e'(ctrlQ[DIV_HI:DIV_LO]);
    unique case (divCode)
      DIV_1:   begin fire = 1'b1;           wrapAt = 2'd0; end
      DIV_1P5: begin fire = (phase != 2'd2); wrapAt = 2'd2; end
      DIV_2:   begin fire = (phase == 2'd0); wrapAt = 2'd1; end
      default: begin fire = (phase == 2'd0); wrapAt = 2'd2; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
      phase <= '0;
    end else if (wrEn) begin
      ctrlQ <= wrData & CTRL_MASK;
      phase <= '0;
    end else if (srcTick) begin
      phase <= (phase == wrapAt) ? 2'd0 : phase + 2'd1;
    end
  end

  always_comb begin
    strobe.clr = wrEn;
    strobe.adv = srcTick & fire & ~wrEn;
    strobe.dbl = ctrlQ[SPD_BIT];
    isMaster   = ctrlQ[MS_BIT];
  end

  // R2: a write lands in the register with reserved bits cleared
  p_wr_readback_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (ctrlQ == ($past(wrData) & CTRL_MASK)));

  // R3: divide by 2 and by 3 never give two divided ticks in a row
  p_div_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.adv && ctrlQ[DIV_HI]) |=> !strobe.adv);

  // R3: divide by 1.5 gives at most two divided ticks in a row
  p_div_onept5_r3: assert property (@(posedge clk) disable iff (!rstN)
    (divCode == DIV_1P5 && strobe.adv && $past(strobe.adv) && !$past(wrEn))
      |=> !strobe.adv);

endmodule

// File: rtl/acm_clkgen.sv
module acm_clkgen
  import acm_pkg::*;
#(
  parameter int unsigned BITS_PER_FRAME = 64,
  parameter int unsigned SSM_RATIO      = 256
) (
  input  logic      clk,
  input  logic      rstN,
  input  cgStrobe_t strobe,
  output logic      bclk,
  output logic      lrck
);

  localparam int unsigned CNT_W   = $clog2(SSM_RATIO);
  localparam int unsigned BCLK_HI = $clog2(SSM_RATIO / BITS_PER_FRAME) - 1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clr) cnt <= '0;
    else if (strobe.adv)     cnt <= cnt + 1'b1;
  end

  always_comb begin
    if (strobe.dbl) begin
      lrck = cnt[CNT_W-2];
      bclk = cnt[BCLK_HI-1];
    end else begin
      lrck = cnt[CNT_W-1];
      bclk = cnt[BCLK_HI];
    end
  end

  // R6: a write restarts both clocks low
  p_clr_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clr |=> (!lrck && !bclk));

  // R9: clock edges only follow a divided tick or a write
  p_sync_edge_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(lrck) || !$stable(bclk)) |-> $past(strobe.adv || strobe.clr));

endmodule

// File: rtl/audio_clk_master.sv
module audio_clk_master
  import acm_pkg::*;
#(
  parameter int unsigned BITS_PER_FRAME = 64,
  parameter int unsigned SSM_RATIO      = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       floatClks,
  input  logic       mclkTick1,
  input  logic       mclkTick2,
  input  logic       bclkIn,
  input  logic       lrckIn,
  output logic       bclkOut,
  output logic       lrckOut,
  output logic       bclkOe,
  output logic       lrckOe,
  output logic       bclkPort,
  output logic       lrckPort
);

  cgStrobe_t  strobe;
  logic       isMaster;
  logic       bclkGen;
  logic       lrckGen;
  logic [7:0] ctrlQ;

  acm_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (regWrEn),
    .wrData   (regWrData),
    .tick1    (mclkTick1),
    .tick2    (mclkTick2),
    .ctrlQ    (ctrlQ),
    .isMaster (isMaster),
    .strobe   (strobe)
  );

  acm_clkgen #(
    .BITS_PER_FRAME (BITS_PER_FRAME),
    .SSM_RATIO      (SSM_RATIO)
  ) u_clkgen (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .bclk   (bclkGen),
    .lrck   (lrckGen)
  );

  always_comb begin
    regRdData = ctrlQ;
    bclkOut   = bclkGen;
    lrckOut   = lrckGen;
    bclkOe    = isMaster & ~floatClks;
    lrckOe    = isMaster & ~floatClks;
    bclkPort  = isMaster ? bclkGen : bclkIn;
    lrckPort  = isMaster ? lrckGen : lrckIn;
  end

  // R8: floating or slave keeps both pin drivers off
  p_oe_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    (floatClks || !regRdData[MS_BIT]) |-> (!bclkOe && !lrckOe));

endmodule

// File: tb/sim_audio_clk_master.sv
module sim_audio_clk_master;

  logic       clk = 1'b0;
  logic       rstN;
  logic       regWrEn;
  logic [7:0] regWrData;
  logic [7:0] regRdData;
  logic       floatClks;
  logic       mclkTick1, mclkTick2;
  logic       bclkIn, lrckIn;
  logic       bclkOut, lrckOut, bclkOe, lrckOe, bclkPort, lrckPort;

  int checks = 0;
  int errors = 0;
  localparam int LEN = 1600;

  always #2 clk = ~clk;

  audio_clk_master u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .floatClks(floatClks),
    .mclkTick1(mclkTick1), .mclkTick2(mclkTick2),
    .bclkIn(bclkIn), .lrckIn(lrckIn),
    .bclkOut(bclkOut), .lrckOut(lrckOut), .bclkOe(bclkOe), .lrckOe(lrckOe),
    .bclkPort(bclkPort), .lrckPort(lrckPort)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wrCtrl(input logic [7:0] v);
    regWrEn   = 1'b1;
    regWrData = v;
    mclkTick1 = 1'b0;
    mclkTick2 = 1'b0;
    step();
    regWrEn = 1'b0;
  endtask

  // divided ticks after n selected source ticks (R3)
  function automatic int divCount(input int code, input int n);
    case (code)
      0:       return n;
      1:       return 2 * (n / 3) + (n % 3);
      2:       return (n + 1) / 2;
      default: return (n + 2) / 3;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regWrData = '0; floatClks = 1'b0;
    mclkTick1 = 1'b0; mclkTick2 = 1'b0; bclkIn = 1'b0; lrckIn = 1'b0;
    @(negedge clk);
    step(); step();
    rstN = 1'b1;
    step();

    // R1 reset state
    chk(regRdData == 8'h00, "R1 reset word", regRdData, 0);
    chk(!bclkOe && !lrckOe, "R1 reset oe", {bclkOe, lrckOe}, 0);

    // R2 reserved bits
    wrCtrl(8'hFF);
    chk(regRdData == 8'hE5, "R2 write FF", regRdData, 8'hE5);
    wrCtrl(8'h1A);
    chk(regRdData == 8'h00, "R2 write 1A", regRdData, 0);

    // R7 R8 slave pass-through, float ignored
    for (int f = 0; f < 2; f++) begin
      floatClks = f[0];
      for (int p = 0; p < 4; p++) begin
        bclkIn = p[0]; lrckIn = p[1];
        mclkTick1 = 1'b1; mclkTick2 = 1'b1;
        step();
        chk(bclkPort == p[0] && lrckPort == p[1], "R7 slave pass",
            {bclkPort, lrckPort}, {p[0], p[1]});
        chk(!bclkOe && !lrckOe, "R8 slave oe low", {bclkOe, lrckOe}, 0);
      end
    end

    // R8 master with float set
    floatClks = 1'b1;
    wrCtrl(8'h20);
    chk(!bclkOe && !lrckOe, "R8 master float oe", {bclkOe, lrckOe}, 0);
    floatClks = 1'b0;
    step();
    chk(bclkOe && lrckOe, "R8 master drive oe", {bclkOe, lrckOe}, 3);

    // R3 R4 R5 R9 sweep over source, divider and speed
    for (int src = 0; src < 2; src++) begin
      for (int code = 0; code < 4; code++) begin
        for (int spd = 0; spd < 2; spd++) begin
          automatic logic [7:0] cfg;
          automatic int n = 0;
          cfg = {code[1:0], 1'b1, 2'b00, spd[0], 1'b0, src[0]};
          wrCtrl(cfg);
          chk(regRdData == cfg, "R2 sweep word", regRdData, cfg);
          for (int i = 0; i < LEN; i++) begin
            automatic int d = divCount(code, n);
            automatic logic expL = spd ? d[6] : d[7];
            automatic logic expB = spd ? d[0] : d[1];
            chk(lrckPort == expL && bclkPort == expB && lrckOut == expL &&
                bclkOut == expB, "R3 R4 R5 R9 clocks",
                {lrckPort, bclkPort}, {expL, expB});
            mclkTick1 = ((i % 3) != 1);
            mclkTick2 = ((i % 2) == 0);
            if (src == 0 ? mclkTick1 : mclkTick2) n++;
            step();
          end
          // R6 rewrite with a tick present in the same cycle
          regWrEn = 1'b1; regWrData = cfg; mclkTick1 = 1'b1; mclkTick2 = 1'b1;
          step();
          regWrEn = 1'b0; mclkTick1 = 1'b0; mclkTick2 = 1'b0;
          chk(!lrckPort && !bclkPort, "R6 restart low", {lrckPort, bclkPort}, 0);
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule